// File: doc/BRIEF.md
# Decode Stage Skid Buffer Controller

This block is the decode stage of a single-thread instruction pipeline. Each cycle the fetch side presents a group of up to `FETCH_W` instruction lanes, each carrying a sequence number, an opaque payload and a killed mark. The stage forwards up to `DEC_W` live instructions per cycle to the rename side. Work it cannot pass on is held in an internal skid buffer. The buffer holds `F2D_DELAY * FETCH_W + DEC_W` entries, so it can absorb everything fetch sends before a hold request reaches it.

Three downstream stages (rename, execute, commit) each raise a stall pulse and later a go pulse. The stage keeps one sticky flag per source. It also reacts to a flush request from commit and to a "flush still in progress" level. A five-state controller selects the action each cycle. It tells fetch to hold (`fetch_block`) and to resume (`fetch_unblock`). It resumes fetch only once the skid buffer has fully drained, and while draining it serves the buffer ahead of any new fetch input.

Top module: `decode_skid_ctrl`

## Requirements
- R1: After reset, `state` is Idle (code 0), all output valids, `fetch_block`, `fetch_unblock`, `activity` and `overflow` are low, all stall flags are clear and the skid buffer is empty.
- R2: Each of the three stall flags is set by its source's stall pulse and cleared by its go pulse; a go pulse wins over a stall pulse in the same cycle, and the updated flag already governs that cycle's decision.
- R3: Each cycle the first matching condition decides: commit flush, then flush-in-progress, then any stall flag set, then leaving Blocked, then leaving Squashing.
- R4: A commit flush drops the cycle's input, empties the skid buffer and enters Squashing (code 4); if the state was Blocked or Unblocking it also pulses `fetch_unblock`.
- R5: While flush-in-progress is high, the stage stays in Squashing, drops its input and empties the skid buffer; from Squashing with no flush and no stall, it moves to Running and handles that cycle's input as Running does.
- R6: With any stall flag set, the cycle's live instructions are appended to the skid buffer and the state becomes Blocked (code 2); `fetch_block` pulses only if the state was not already Blocked.
- R7: Blocked with no stall flag set behaves as Unblocking (code 3) in that same cycle. In Unblocking, up to `DEC_W` entries leave the skid buffer oldest first, then the cycle's live instructions are appended behind them; fresh input is never forwarded directly.
- R8: When the skid buffer is empty at the end of an Unblocking cycle, `fetch_unblock` pulses and the state becomes Running (code 1); otherwise the state stays Unblocking.
- R9: In Idle or Running, live instructions go out in lane order into output slots starting at slot 0, at most `DEC_W` per cycle. Lanes with `in_kill` set use no slot. If live instructions remain, they enter the skid buffer, the state becomes Blocked and `fetch_block` pulses.
- R10: An append that finds the skid buffer full is dropped and sets `overflow`, which stays high until reset.
- R11: `activity` is high exactly on cycles whose response forwards at least one instruction or pulses `fetch_block` or `fetch_unblock`.
- R12: All outputs are registered, so the response to a cycle's inputs appears after the next rising edge. Idle moves to Running on the first cycle that forwards an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | FETCH_W | Lane valid from fetch |
| in_kill | input | FETCH_W | Lane carries an already-killed instruction |
| in_seq | input | FETCH_W*SEQ_W | Sequence number per lane |
| in_pay | input | FETCH_W*PAY_W | Opaque payload per lane |
| ren_stall | input | 1 | Rename stall pulse |
| ren_go | input | 1 | Rename go pulse |
| exe_stall | input | 1 | Execute stall pulse |
| exe_go | input | 1 | Execute go pulse |
| cmt_stall | input | 1 | Commit stall pulse |
| cmt_go | input | 1 | Commit go pulse |
| cmt_squash | input | 1 | Commit flush request |
| cmt_squashing | input | 1 | Commit flush still in progress |
| out_vld | output | DEC_W | Output slot valid toward rename |
| out_seq | output | DEC_W*SEQ_W | Sequence number per output slot |
| out_pay | output | DEC_W*PAY_W | Payload per output slot |
| fetch_block | output | 1 | Hold request pulse to fetch |
| fetch_unblock | output | 1 | Resume pulse to fetch |
| activity | output | 1 | Stage did visible work this cycle |
| overflow | output | 1 | Sticky skid buffer overflow flag |
| state | output | 3 | Controller state code |

## Verification
Draining the skid buffer and appending fresh fetch input can happen in the same cycle. The bench provokes this by releasing a stall while fetch keeps delivering lanes. It judges the result by the sequence numbers that come out afterwards: the older buffered entries must appear strictly before the new ones, and `fetch_unblock` must wait for the cycle in which the buffer ends empty. A flush arriving together with a stall, or with leftovers that would block, is the second overlap checked, and there Squashing must win with no hold pulse. A reference model in the bench predicts every registered output on each vector of sweeps over all lane-valid and killed masks and over mixed stall, go and flush traffic.

// File: rtl/decode_skid_ctrl.sv
module decode_skid_ctrl #(
  parameter int FETCH_W   = 4,
  parameter int DEC_W     = 2,
  parameter int F2D_DELAY = 1,
  parameter int SEQ_W     = 6,
  parameter int PAY_W     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [FETCH_W-1:0]       in_vld,
  input  logic [FETCH_W-1:0]       in_kill,
  input  logic [FETCH_W*SEQ_W-1:0] in_seq,
  input  logic [FETCH_W*PAY_W-1:0] in_pay,
  input  logic                     ren_stall,
  input  logic                     ren_go,
  input  logic                     exe_stall,
  input  logic                     exe_go,
  input  logic                     cmt_stall,
  input  logic                     cmt_go,
  input  logic                     cmt_squash,
  input  logic                     cmt_squashing,
  output logic [DEC_W-1:0]         out_vld,
  output logic [DEC_W*SEQ_W-1:0]   out_seq,
  output logic [DEC_W*PAY_W-1:0]   out_pay,
  output logic                     fetch_block,
  output logic                     fetch_unblock,
  output logic                     activity,
  output logic                     overflow,
  output logic [2:0]               state
);
  localparam int DEPTH = F2D_DELAY * FETCH_W + DEC_W;
  localparam int EW    = SEQ_W + PAY_W;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  localparam logic [2:0] S_IDLE = 3'd0;
  localparam logic [2:0] S_RUN  = 3'd1;
  localparam logic [2:0] S_BLK  = 3'd2;
  localparam logic [2:0] S_UNB  = 3'd3;
  localparam logic [2:0] S_SQ   = 3'd4;

  logic [2:0]         st_q, st_n;
  logic [2:0]         flg_q, flg_now;
  logic [EW-1:0]      mem [DEPTH];
  logic [AW-1:0]      head_q, head_n;
  logic [CW-1:0]      cnt_q, cnt_n;
  logic               ovf_now, fb_n, fu_n;
  logic [DEC_W-1:0]   ov_n;
  logic [DEC_W*SEQ_W-1:0] os_n;
  logic [DEC_W*PAY_W-1:0] op_n;
  logic [FETCH_W-1:0] wr_en;
  logic [AW-1:0]      wr_idx [FETCH_W];

  assign flg_now[0] = !ren_go && (ren_stall || flg_q[0]);
  assign flg_now[1] = !exe_go && (exe_stall || flg_q[1]);
  assign flg_now[2] = !cmt_go && (cmt_stall || flg_q[2]);
  assign state = st_q;

  function automatic int wrap(input int x);
    return (x >= DEPTH) ? x - DEPTH : x;
  endfunction

  always_comb begin
    int nkeep, pop, cmid, hmid, base, npush, rk, pos;
    logic clr, drain, from_fetch, push_en;
    logic [EW-1:0] e;
    st_n = st_q; fb_n = 1'b0; fu_n = 1'b0; ovf_now = 1'b0;
    clr = 1'b0; drain = 1'b0; from_fetch = 1'b0; push_en = 1'b0;
    base = 0; npush = 0; rk = 0; pos = 0; e = '0;
    ov_n = '0; os_n = '0; op_n = '0; wr_en = '0;
    for (int i = 0; i < FETCH_W; i++) wr_idx[i] = '0;
    nkeep = 0;
    for (int i = 0; i < FETCH_W; i++)
      if (in_vld[i] && !in_kill[i]) nkeep++;

    if (cmt_squash) begin
      st_n = S_SQ; clr = 1'b1;
      fu_n = (st_q == S_BLK) || (st_q == S_UNB);
    end else if (cmt_squashing) begin
      st_n = S_SQ; clr = 1'b1;
    end else if (|flg_now) begin
      st_n = S_BLK; push_en = 1'b1;
      fb_n = (st_q != S_BLK);
    end else if (st_q == S_BLK || st_q == S_UNB) begin
      drain = 1'b1; push_en = 1'b1;
    end else begin
      from_fetch = 1'b1; base = DEC_W;
      if (nkeep > DEC_W) begin
        push_en = 1'b1; st_n = S_BLK; fb_n = 1'b1;
      end else if (st_q != S_IDLE || nkeep > 0) begin
        st_n = S_RUN;
      end
    end

    pop  = drain ? ((int'(cnt_q) < DEC_W) ? int'(cnt_q) : DEC_W) : 0;
    cmid = clr ? 0 : int'(cnt_q) - pop;
    hmid = wrap(int'(head_q) + pop);

    for (int k = 0; k < DEC_W; k++) begin
      if (k < pop) begin
        e = mem[AW'(wrap(int'(head_q) + k))];
        ov_n[k] = 1'b1;
        os_n[k*SEQ_W +: SEQ_W] = e[EW-1 -: SEQ_W];
        op_n[k*PAY_W +: PAY_W] = e[PAY_W-1:0];
      end
    end

    for (int i = 0; i < FETCH_W; i++) begin
      if (in_vld[i] && !in_kill[i]) begin
        if (from_fetch && rk < DEC_W) begin
          ov_n[rk] = 1'b1;
          os_n[rk*SEQ_W +: SEQ_W] = in_seq[i*SEQ_W +: SEQ_W];
          op_n[rk*PAY_W +: PAY_W] = in_pay[i*PAY_W +: PAY_W];
        end else if (push_en && rk >= base) begin
          pos = cmid + rk - base;
          if (pos < DEPTH) begin
            wr_en[i]  = 1'b1;
            wr_idx[i] = AW'(wrap(hmid + pos));
            npush++;
          end else begin
            ovf_now = 1'b1;
          end
        end
        rk++;
      end
    end

    cnt_n  = CW'(cmid + npush);
    head_n = AW'(hmid);
    if (drain) begin
      if (cmid + npush == 0) begin
        fu_n = 1'b1; st_n = S_RUN;
      end else begin
        st_n = S_UNB;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE; flg_q <= '0; head_q <= '0; cnt_q <= '0;
      out_vld <= '0; out_seq <= '0; out_pay <= '0;
      fetch_block <= 1'b0; fetch_unblock <= 1'b0;
      activity <= 1'b0; overflow <= 1'b0;
    end else begin
      st_q <= st_n; flg_q <= flg_now; head_q <= head_n; cnt_q <= cnt_n;
      out_vld <= ov_n; out_seq <= os_n; out_pay <= op_n;
      fetch_block <= fb_n; fetch_unblock <= fu_n;
      activity <= (|ov_n) || fb_n || fu_n;
      overflow <= overflow || ovf_now;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < FETCH_W; i++)
      if (wr_en[i]) mem[wr_idx[i]] <= {in_seq[i*SEQ_W +: SEQ_W], in_pay[i*PAY_W +: PAY_W]};
  end

  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= DEPTH);
  a_r4_squash_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_squash |=> (st_q == S_SQ) && (cnt_q == '0));
  a_r8_unblock_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_unblock |-> (cnt_q == '0));
  a_r5_squashing_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_SQ) |-> (out_vld == '0));
  a_r9_slots_dense: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_vld + DEC_W'(1)) & out_vld) == '0);
  a_r6_block_unblock_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_block && fetch_unblock));
  a_r2_go_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ren_go |=> !flg_q[0]);
  a_r11_activity_on_output: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_vld) |-> activity);
endmodule

// File: tb/tb_decode_skid_ctrl.sv
`timescale 1ns/1ps
module tb_decode_skid_ctrl;
  localparam int FW = 4, DW = 2, SW = 6, PW = 8, DEPTH = FW + DW;
  localparam int IDLE = 0, RUN = 1, BLK = 2, UNB = 3, SQ = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [FW-1:0] iv = '0, ik = '0;
  logic [FW*SW-1:0] iseq = '0;
  logic [FW*PW-1:0] ipay = '0;
  logic rs = 0, rg = 0, es = 0, eg = 0, cs = 0, cg = 0, sq = 0, sqg = 0;
  logic [DW-1:0] out_vld;
  logic [DW*SW-1:0] out_seq;
  logic [DW*PW-1:0] out_pay;
  logic fetch_block, fetch_unblock, activity, overflow;
  logic [2:0] state;

  decode_skid_ctrl dut (
    .clk(clk), .rst_n(rst_n), .in_vld(iv), .in_kill(ik), .in_seq(iseq), .in_pay(ipay),
    .ren_stall(rs), .ren_go(rg), .exe_stall(es), .exe_go(eg), .cmt_stall(cs), .cmt_go(cg),
    .cmt_squash(sq), .cmt_squashing(sqg), .out_vld(out_vld), .out_seq(out_seq),
    .out_pay(out_pay), .fetch_block(fetch_block), .fetch_unblock(fetch_unblock),
    .activity(activity), .overflow(overflow), .state(state));

  always #2.5 clk = ~clk;

  int nvec = 0, nfail = 0, seqc = 0;
  int ms = IDLE;
  bit mf[3];
  bit movf = 0;
  int mq[$];

  task automatic apply(input logic [3:0] v, input logic [3:0] k, input logic [5:0] sg,
                       input logic fsq, input logic fsqg, input string tag);
    int ks[$]; int outs[$]; int ns; bit fb, fu, anyf, act;
    logic [DW-1:0] ev; logic [DW*SW-1:0] es_x; logic [DW*PW-1:0] ep_x;
    logic [36:0] expv, actv;
    fb = 0; fu = 0; ns = ms;
    for (int l = 0; l < FW; l++) begin
      logic [SW-1:0] s; logic [PW-1:0] p;
      s = SW'(seqc); p = PW'($urandom); seqc++;
      iseq[l*SW +: SW] = s; ipay[l*PW +: PW] = p;
      if (v[l] && !k[l]) ks.push_back((int'(s) << PW) | int'(p));
    end
    iv = v; ik = k;
    {cg, cs, eg, es, rg, rs} = sg; sq = fsq; sqg = fsqg;
    mf[0] = !sg[1] && (sg[0] || mf[0]);
    mf[1] = !sg[3] && (sg[2] || mf[1]);
    mf[2] = !sg[5] && (sg[4] || mf[2]);
    anyf = mf[0] || mf[1] || mf[2];
    if (fsq) begin
      fu = (ms == BLK) || (ms == UNB); mq.delete(); ns = SQ;
    end else if (fsqg) begin
      mq.delete(); ns = SQ;
    end else if (anyf) begin
      fb = (ms != BLK); ns = BLK;
      foreach (ks[i]) if (mq.size() < DEPTH) mq.push_back(ks[i]); else movf = 1;
    end else if (ms == BLK || ms == UNB) begin
      for (int n = 0; n < DW && mq.size() > 0; n++) outs.push_back(mq.pop_front());
      foreach (ks[i]) if (mq.size() < DEPTH) mq.push_back(ks[i]); else movf = 1;
      if (mq.size() == 0) begin fu = 1; ns = RUN; end else ns = UNB;
    end else begin
      foreach (ks[i]) begin
        if (i < DW) outs.push_back(ks[i]);
        else if (mq.size() < DEPTH) mq.push_back(ks[i]);
        else movf = 1;
      end
      if (ks.size() > DW) begin fb = 1; ns = BLK; end
      else if (ms != IDLE || ks.size() > 0) ns = RUN;
    end
    act = (outs.size() > 0) || fb || fu;
    ev = '0; es_x = '0; ep_x = '0;
    foreach (outs[i]) begin
      ev[i] = 1'b1;
      es_x[i*SW +: SW] = SW'(outs[i] >> PW);
      ep_x[i*PW +: PW] = PW'(outs[i]);
    end
    ms = ns;
    @(posedge clk); #1;
    nvec++;
    expv = {ev, es_x, ep_x, fb, fu, act, movf, 3'(ns)};
    actv = {out_vld, out_seq, out_pay, fetch_block, fetch_unblock, activity, overflow, state};
    if (actv !== expv) begin
      nfail++;
      $display("FAIL %s vector %0d: actual=%h expected=%h", tag, nvec, actv, expv);
    end
  endtask

  initial begin
    #(200000 * 5);
    nfail++;
    $display("FAIL watchdog R1 run: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    apply(4'b0000, 4'b0000, 6'b000000, 0, 0, "R1 reset state");
    apply(4'b0000, 4'b0000, 6'b000000, 0, 0, "R11 idle no activity");
    apply(4'b0011, 4'b0000, 6'b000000, 0, 0, "R12 idle to running");
    apply(4'b1111, 4'b0010, 6'b000000, 0, 0, "R9 leftover blocks");
    apply(4'b0000, 4'b0000, 6'b000000, 0, 0, "R8 drain then unblock");
    apply(4'b0000, 4'b0000, 6'b000001, 0, 0, "R2 rename stall sets flag");
    apply(4'b1111, 4'b0000, 6'b000000, 0, 0, "R6 no second block pulse");
    apply(4'b1111, 4'b0000, 6'b000000, 0, 0, "R10 overflow");
    apply(4'b0000, 4'b0000, 6'b000010, 0, 0, "R7 drain oldest first");
    apply(4'b0011, 4'b0000, 6'b000000, 0, 0, "R7 append behind skid");
    apply(4'b0000, 4'b0000, 6'b000000, 0, 0, "R7 drain");
    apply(4'b0000, 4'b0000, 6'b000000, 0, 0, "R8 unblock when empty");
    apply(4'b0000, 4'b0000, 6'b000101, 0, 0, "R2 two flags");
    apply(4'b0000, 4'b0000, 6'b000010, 0, 0, "R2 one flag still set");
    apply(4'b0000, 4'b0000, 6'b001000, 0, 0, "R2 last flag cleared");
    apply(4'b0000, 4'b0000, 6'b110000, 0, 0, "R2 go wins same cycle");
    apply(4'b0000, 4'b0000, 6'b000100, 0, 0, "R6 block");
    apply(4'b1111, 4'b0000, 6'b000000, 0, 0, "R6 park input");
    apply(4'b0001, 4'b0000, 6'b001000, 1, 0, "R4 squash from blocked");
    apply(4'b1111, 4'b0000, 6'b000000, 0, 1, "R5 still squashing");
    apply(4'b0011, 4'b0000, 6'b000000, 0, 0, "R5 squashing to running");
    apply(4'b1111, 4'b0000, 6'b000001, 1, 0, "R3 squash beats stall");
    apply(4'b0000, 4'b0000, 6'b000010, 0, 1, "R3 squashing beats exit");
    apply(4'b0111, 4'b0000, 6'b000000, 0, 0, "R3 exit squashing");
    apply(4'b0000, 4'b0000, 6'b000000, 0, 0, "R8 drain after leftover");
    for (int v = 0; v < 16; v++)
      for (int k = 0; k < 16; k++) begin
        apply(4'(v), 4'(k), 6'b000000, 0, 0, "R9 lane mask sweep");
        repeat (2) apply(4'b0000, 4'b0000, 6'b000000, 0, 0, "R8 mask sweep drain");
      end
    for (int n = 0; n < 4000; n++) begin
      logic [5:0] sg;
      sg[0] = ($urandom_range(0, 9) == 0); sg[1] = ($urandom_range(0, 3) == 0);
      sg[2] = ($urandom_range(0, 9) == 0); sg[3] = ($urandom_range(0, 3) == 0);
      sg[4] = ($urandom_range(0, 9) == 0); sg[5] = ($urandom_range(0, 3) == 0);
      apply(4'($urandom), 4'($urandom_range(0, 15) & $urandom_range(0, 15)), sg,
            ($urandom_range(0, 23) == 0), ($urandom_range(0, 15) == 0), "R3 mixed traffic");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule